// File: doc/BRIEF.md
# PHY Interrupt Source and Mask Unit

This block holds the interrupt logic of an Ethernet PHY that sits behind a management register interface. A link-up level comes in from outside the clock domain and is synchronised. Each rising or falling edge of the synchronised level raises its own group of sticky event bits in an 8-bit interrupt source register. Each edge also sets or clears the link-related bits of the basic status register.

Software masks the source bits through an 8-bit mask register. The unit drives one summary request, `irq_o`, to the parent interrupt controller. The request is high whenever a source bit and the matching mask bit are both set. Reading the source register returns its contents and empties it in the same access, so one read acknowledges every pending event.

The unit also holds the control and advertisement registers that sit next to these registers in the management space. Management accesses are single-cycle strobes with a 5-bit register address. Read data is combinational while the read strobe is high, and every register update takes effect at the clock edge that ends the strobe.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset the source and mask registers are 0, basic status (address 1) reads 0x7809, control (address 0) reads 0x3000, advertisement (address 4) reads 0x01E1, and `irq_o` is low.
- R2: A falling edge of `link_up_i` sets source bit 4 (0x10) and clears status bits 0x0024. The effect is visible after the third rising clock edge following the input change: two synchroniser stages, then the edge register.
- R3: A rising edge of `link_up_i` sets source bits 7 and 6 (0xC0) and sets status bits 0x0024, with the same three-edge latency as R2.
- R4: A read of address 29 returns the source register in bits 7:0, with upper bits zero, during the strobe cycle. The register reads zero after that clock edge.
- R5: Address 30 is the mask. A write stores `mgmt_wdata_i[7:0]`, and a read returns the stored mask with bits 15:8 zero.
- R6: `irq_o` is high exactly when (source AND mask) is nonzero. It follows every source or mask update in the cycle after the updating clock edge.
- R7: A write to address 4 stores (wdata AND 0x2D7F) OR 0x0080.
- R8: A write to address 0 stores all 16 bits, and a read of address 0 returns them.
- R9: The status register at address 1 is read-only, so writes to it leave it unchanged.
- R10: Reads of any address other than 0, 1, 4, 29 and 30 return 0. Writes to any address other than 0, 4 and 30, including 29, change no register.
- R11: A link event that lands on the same clock edge as a clearing read of address 29 keeps its own source bits. The read clears only the bits it returned.
- R12: Source bits are sticky and collect regardless of the mask until a read of address 29 clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Asynchronous link-up level |
| mgmt_rd_i | input | 1 | Management read strobe, one cycle per access |
| mgmt_wr_i | input | 1 | Management write strobe, one cycle per access |
| mgmt_addr_i | input | 5 | Management register address |
| mgmt_wdata_i | input | 16 | Management write data |
| mgmt_rdata_o | output | 16 | Read data, valid while `mgmt_rd_i` is high |
| irq_o | output | 1 | Summary interrupt request |

## Verification
Read data is due in the strobe cycle itself, so the bench samples `mgmt_rdata_o` one nanosecond after it raises the strobe on a falling edge, before the next rising edge. Writes and read clears are due one edge later, and `irq_o` is sampled on the falling edge after that. Link events take three rising edges. The bench checks that `irq_o` is still low after two edges and high after the third. For R11 it places the clearing read on exactly the third edge. Random traffic waits out the full link latency before comparing against the bench model.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int PHY_DATA_W = 16;
    localparam int PHY_ADDR_W = 5;
    localparam int PHY_IRQ_W  = 8;

    localparam logic [PHY_ADDR_W-1:0] ADDR_CTRL = 5'd0;
    localparam logic [PHY_ADDR_W-1:0] ADDR_STAT = 5'd1;
    localparam logic [PHY_ADDR_W-1:0] ADDR_ADV  = 5'd4;
    localparam logic [PHY_ADDR_W-1:0] ADDR_SRC  = 5'd29;
    localparam logic [PHY_ADDR_W-1:0] ADDR_MASK = 5'd30;

    localparam logic [PHY_IRQ_W-1:0] EVT_ENERGY_ON  = 8'h80;
    localparam logic [PHY_IRQ_W-1:0] EVT_ANEG_DONE  = 8'h40;
    localparam logic [PHY_IRQ_W-1:0] EVT_REM_FAULT  = 8'h20;
    localparam logic [PHY_IRQ_W-1:0] EVT_LINK_LOST  = 8'h10;
    localparam logic [PHY_IRQ_W-1:0] EVT_LP_ACK     = 8'h08;
    localparam logic [PHY_IRQ_W-1:0] EVT_PAR_FAULT  = 8'h04;
    localparam logic [PHY_IRQ_W-1:0] EVT_PAGE_RX    = 8'h02;

    localparam logic [PHY_IRQ_W-1:0] EVT_UP_SET   = EVT_ENERGY_ON | EVT_ANEG_DONE;
    localparam logic [PHY_IRQ_W-1:0] EVT_DOWN_SET = EVT_LINK_LOST;

    localparam logic [PHY_DATA_W-1:0] STAT_RST      = 16'h7809;
    localparam logic [PHY_DATA_W-1:0] STAT_LINK_BITS = 16'h0024;
    localparam logic [PHY_DATA_W-1:0] CTRL_RST      = 16'h3000;
    localparam logic [PHY_DATA_W-1:0] ADV_RST       = 16'h01E1;
    localparam logic [PHY_DATA_W-1:0] ADV_KEEP      = 16'h2D7F;
    localparam logic [PHY_DATA_W-1:0] ADV_FORCE     = 16'h0080;

    typedef struct packed {
        logic [PHY_IRQ_W-1:0] src;
        logic [PHY_IRQ_W-1:0] mask;
    } irq_state_t;

    typedef struct packed {
        logic [PHY_DATA_W-1:0] ctrl;
        logic [PHY_DATA_W-1:0] stat;
        logic [PHY_DATA_W-1:0] adv;
    } mgmt_state_t;

endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_async_i,
    output logic link_rise_o,
    output logic link_fall_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              level;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        synced;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = link_async_i;
                st_d.level = st_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[LAST-1:0], link_async_i};
                st_d.level = st_q.chain[LAST];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced      = st_q.chain[LAST];
    assign link_rise_o = synced & ~st_q.level;
    assign link_fall_o = ~synced & st_q.level;

endmodule

// File: rtl/phy_irq_src.sv
module phy_irq_src
    import phy_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_rise_i,
    input  logic                 link_fall_i,
    input  logic                 src_clr_i,
    input  logic                 mask_we_i,
    input  logic [PHY_IRQ_W-1:0] mask_wdata_i,
    output logic [PHY_IRQ_W-1:0] src_o,
    output logic [PHY_IRQ_W-1:0] mask_o,
    output logic                 irq_o
);

    irq_state_t st_d, st_q;
    logic [PHY_IRQ_W-1:0] set_bits;

    always_comb begin
        set_bits = '0;
        if (link_rise_i) begin
            set_bits = set_bits | EVT_UP_SET;
        end
        if (link_fall_i) begin
            set_bits = set_bits | EVT_DOWN_SET;
        end
    end

    always_comb begin
        st_d = st_q;
        // a clearing read drops only what it returned; new events survive
        if (src_clr_i) begin
            st_d.src = '0;
        end
        st_d.src = st_d.src | set_bits;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o  = st_q.src;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.src & st_q.mask);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  link_rise_i,
    input  logic                  link_fall_i,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [PHY_ADDR_W-1:0] addr_i,
    input  logic [PHY_DATA_W-1:0] wdata_i,
    input  logic [PHY_IRQ_W-1:0]  src_i,
    input  logic [PHY_IRQ_W-1:0]  mask_i,
    output logic [PHY_DATA_W-1:0] rdata_o,
    output logic [PHY_DATA_W-1:0] stat_o,
    output logic                  src_clr_o,
    output logic                  mask_we_o
);

    localparam int PAD_W = PHY_DATA_W - PHY_IRQ_W;

    mgmt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                ADDR_CTRL: st_d.ctrl = wdata_i;
                ADDR_ADV:  st_d.adv  = (wdata_i & ADV_KEEP) | ADV_FORCE;
                default:   ;
            endcase
        end
        if (link_rise_i) begin
            st_d.stat = st_q.stat | STAT_LINK_BITS;
        end else if (link_fall_i) begin
            st_d.stat = st_q.stat & ~STAT_LINK_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.stat <= STAT_RST;
            st_q.adv  <= ADV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                ADDR_CTRL: rdata_o = st_q.ctrl;
                ADDR_STAT: rdata_o = st_q.stat;
                ADDR_ADV:  rdata_o = st_q.adv;
                ADDR_SRC:  rdata_o = {{PAD_W{1'b0}}, src_i};
                ADDR_MASK: rdata_o = {{PAD_W{1'b0}}, mask_i};
                default:   rdata_o = '0;
            endcase
        end
    end

    assign src_clr_o = rd_i && (addr_i == ADDR_SRC);
    assign mask_we_o = wr_i && (addr_i == ADDR_MASK);
    assign stat_o    = st_q.stat;

endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
    import phy_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  link_up_i,
    input  logic                  mgmt_rd_i,
    input  logic                  mgmt_wr_i,
    input  logic [PHY_ADDR_W-1:0] mgmt_addr_i,
    input  logic [PHY_DATA_W-1:0] mgmt_wdata_i,
    output logic [PHY_DATA_W-1:0] mgmt_rdata_o,
    output logic                  irq_o
);

    logic                  link_rise;
    logic                  link_fall;
    logic                  src_clr;
    logic                  mask_we;
    logic [PHY_IRQ_W-1:0]  src_q;
    logic [PHY_IRQ_W-1:0]  mask_q;
    logic [PHY_DATA_W-1:0] status_q;

    phy_link_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_async_i (link_up_i),
        .link_rise_o  (link_rise),
        .link_fall_o  (link_fall)
    );

    phy_irq_src u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_rise_i  (link_rise),
        .link_fall_i  (link_fall),
        .src_clr_i    (src_clr),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mgmt_wdata_i[PHY_IRQ_W-1:0]),
        .src_o        (src_q),
        .mask_o       (mask_q),
        .irq_o        (irq_o)
    );

    phy_mgmt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_rise_i (link_rise),
        .link_fall_i (link_fall),
        .rd_i        (mgmt_rd_i),
        .wr_i        (mgmt_wr_i),
        .addr_i      (mgmt_addr_i),
        .wdata_i     (mgmt_wdata_i),
        .src_i       (src_q),
        .mask_i      (mask_q),
        .rdata_o     (mgmt_rdata_o),
        .stat_o      (status_q),
        .src_clr_o   (src_clr),
        .mask_we_o   (mask_we)
    );

endmodule

// File: rtl/phy_irq_checker.sv
module phy_irq_checker
    import phy_irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mgmt_rd_i,
    input logic                  mgmt_wr_i,
    input logic [PHY_ADDR_W-1:0] mgmt_addr_i,
    input logic [PHY_DATA_W-1:0] mgmt_wdata_i,
    input logic                  irq_o,
    input logic                  link_rise,
    input logic                  link_fall,
    input logic [PHY_IRQ_W-1:0]  src_q,
    input logic [PHY_IRQ_W-1:0]  mask_q,
    input logic [PHY_DATA_W-1:0] status_q
);

    logic rd_src;
    logic wr_mask;
    assign rd_src  = mgmt_rd_i && (mgmt_addr_i == ADDR_SRC);
    assign wr_mask = mgmt_wr_i && (mgmt_addr_i == ADDR_MASK);

    p_link_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (src_q[4] && ((status_q & STAT_LINK_BITS) == '0)));

    p_link_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        link_rise |=> (src_q[7] && src_q[6] && ((status_q & STAT_LINK_BITS) == STAT_LINK_BITS)));

    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src && !link_rise && !link_fall) |=> (src_q == '0));

    p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(mgmt_wdata_i[PHY_IRQ_W-1:0])));

    p_irq_masked_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && (mgmt_wdata_i[PHY_IRQ_W-1:0] == '0)) |=> !irq_o);

    p_irq_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rise && mask_q[7] && !mgmt_wr_i) |=> irq_o);

    p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_rise && !link_fall) |=> $stable(status_q));

    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src && link_fall) |=> (src_q == EVT_DOWN_SET));

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_src && !link_rise && !link_fall) |=> $stable(src_q));

endmodule

bind phy_irq_unit phy_irq_checker u_chk (.*);

// File: tb/test_phy_irq_unit.sv
`timescale 1ns/1ps
module test_phy_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_src, m_mask;
    logic        m_link;

    always #5 clk = ~clk;

    phy_irq_unit i_phy_irq_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_up_i    (link_up),
        .mgmt_rd_i    (rd),
        .mgmt_wr_i    (wr),
        .mgmt_addr_i  (addr),
        .mgmt_wdata_i (wdata),
        .mgmt_rdata_o (rdata),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        case (a)
            5'd0:    return m_ctrl;
            5'd1:    return m_stat;
            5'd4:    return m_adv;
            5'd29:   return {8'h00, m_src};
            5'd30:   return {8'h00, m_mask};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_src & m_mask);
    endfunction

    task automatic mg_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
        if (a == 5'd29) m_src = '0;
    endtask

    task automatic mg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        case (a)
            5'd0:  m_ctrl = d;
            5'd4:  m_adv  = (d & 16'h2D7F) | 16'h0080;
            5'd30: m_mask = d[7:0];
            default: ;
        endcase
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        repeat (3) @(negedge clk);
        if (v && !m_link) begin
            m_src  = m_src | 8'hC0;
            m_stat = m_stat | 16'h0024;
        end else if (!v && m_link) begin
            m_src  = m_src | 8'h10;
            m_stat = m_stat & ~16'h0024;
        end
        m_link = v;
    endtask

    task automatic read_check(input string req, input logic [4:0] a);
        logic [15:0] d;
        logic [15:0] e;
        e = exp_read(a);
        mg_read(a, d);
        check(req, d, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
        m_src = '0; m_mask = '0; m_link = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'h0000);
        read_check("R1 ctrl", 5'd0);
        read_check("R1 status", 5'd1);
        read_check("R1 adv", 5'd4);
        read_check("R1 src", 5'd29);
        read_check("R1 mask", 5'd30);

        // R5 mask keeps low 8 bits
        mg_write(5'd30, 16'hABCD);
        read_check("R5 mask", 5'd30);
        mg_write(5'd30, 16'h00FF);

        // R3 / R6 link up latency
        @(negedge clk);
        link_up = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 irq before third edge", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        check("R6 irq after third edge", {15'd0, irq}, 16'h0001);
        m_src = 8'hC0; m_stat = m_stat | 16'h0024; m_link = 1'b1;
        read_check("R3 status", 5'd1);
        read_check("R3 src", 5'd29);
        read_check("R4 src cleared", 5'd29);
        check("R6 irq after clear", {15'd0, irq}, 16'h0000);

        // R2 link down
        set_link(1'b0);
        check("R6 irq down", {15'd0, irq}, 16'h0001);
        read_check("R2 status", 5'd1);
        read_check("R2 src", 5'd29);

        // R12 sticky accumulation under zero mask
        mg_write(5'd30, 16'h0000);
        set_link(1'b1);
        set_link(1'b0);
        check("R12 irq masked", {15'd0, irq}, 16'h0000);
        read_check("R12 src", 5'd29);

        // R7 advertisement
        mg_write(5'd4, 16'hFFFF);
        read_check("R7 adv ones", 5'd4);
        mg_write(5'd4, 16'h0000);
        read_check("R7 adv zero", 5'd4);

        // R8 control
        mg_write(5'd0, 16'h1234);
        read_check("R8 ctrl", 5'd0);

        // R9 status read-only
        mg_write(5'd1, 16'h0000);
        read_check("R9 status", 5'd1);

        // R10 unsupported addresses
        read_check("R10 read addr 2", 5'd2);
        read_check("R10 read addr 31", 5'd31);
        mg_write(5'd30, 16'h00FF);
        set_link(1'b1);
        mg_write(5'd29, 16'h0000);
        mg_write(5'd7, 16'hFFFF);
        check("R10 irq kept", {15'd0, irq}, 16'h0001);
        read_check("R10 src kept", 5'd29);
        read_check("R10 mask kept", 5'd30);
        read_check("R10 ctrl kept", 5'd0);

        // R11 read clear on the same edge as a link event
        mg_write(5'd30, 16'h0000);
        @(negedge clk);
        link_up = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd = 1'b1; addr = 5'd29;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
        check("R11 read value", d, 16'h0000);
        m_src = 8'h10; m_stat = m_stat & ~16'h0024; m_link = 1'b0;
        read_check("R11 event kept", 5'd29);

        // random traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [4:0] a;
            op = $urandom_range(0, 9);
            a = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31))
                : ((op & 1) ? 5'd29 : 5'd30);
            if (op < 2) begin
                set_link(~m_link);
            end else if (op < 6) begin
                read_check("R4 random read", a);
            end else begin
                mg_write(a, 16'($urandom()));
            end
            check("R6 random irq", {15'd0, irq}, {15'd0, exp_irq()});
        end

        finish_run();
    end

endmodule